// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave-side front end of a small serial EEPROM. It watches the serial clock, chip select and data-in pins, which arrive as ordinary inputs to a faster system clock. It accepts either SPI clock idle level (mode 0 or mode 3). Bits are taken in on each rising serial clock edge and driven out on each falling edge, most significant bit first. Each frame starts with a one-byte command. The block recognises six commands: set the write latch, clear the write latch, read the status byte, load the two protection bits, stream bytes out of the array, and pass bytes on for programming. The ninth address bit travels inside the command byte.

The block holds the volatile write-enable latch, the protection bits shown in the status byte, and a 512-byte array model for reads. Programming itself is done by a separate commit engine. That engine receives each incoming data byte with its address. It gets a commit pulse when a write frame ends correctly, and it reports its busy time back through `busy`. The same engine fills the array through a plain write port.

Top module: `spi_eeprom_frontend`

## Requirements
- R1: A command byte is decoded only when its bits 7..4 are zero. Bits 2..0 then select the command: 110 sets the write latch, 100 clears it, 101 reads the status byte, 001 loads the protection bits, 011 reads the array, and 010 writes the array. Bit 3 is ignored for the first four commands. For the array commands, bit 3 is address bit 8, and the next byte gives address bits 7..0.
- R2: The status byte is {1,1,1,1,P1,P0,L,B}, where P1/P0 are the protection bits, L is the write latch and B is `busy`. It is sent MSB first, and a fresh copy is taken at each byte boundary for as long as chip select stays low.
- R3: The set and clear latch commands act only if chip select rises after exactly eight rising clock edges. An extra clock edge cancels the command.
- R4: The write latch is cleared by reset, by the clear command, whenever `wp_n` is low, and in the cycle after `busy` falls.
- R5: In a read, the first data bit appears at the first falling edge after the sixteenth rising edge. The address then advances by one per byte and wraps from 511 to 0.
- R6: In a write, each complete data byte is presented for one cycle on `wr_byte_valid` with its address. The address advances inside a 16-byte page and wraps to the page start. `wr_commit` pulses only if chip select rises on a byte boundary after at least one data byte, with the latch set.
- R7: In the protection-load command, bits 3..2 of the data byte become P1/P0 on `sr_bp`, with a pulse on `sr_commit`. This happens only if chip select rises right after the sixteenth rising edge.
- R8: After a protection load, the status byte keeps showing the old P1/P0 until `busy` falls. It then shows the new ones.
- R9: Write and protection-load commands are refused when the latch is clear. Read, write and protection-load commands are refused while `busy` is high. A status read is accepted while `busy` is high.
- R10: After an undefined command byte, the rest of the frame is ignored and `miso_oe` stays low. The next frame is decoded normally.
- R11: `miso_oe` is high only during the data phase of a read or status command. It rises on the first falling edge of that phase and drops one cycle after chip select goes high.
- R12: After reset, a frame starts only on a falling edge of chip select. If chip select is held low through reset, that period is not a frame.
- R13: A frame whose clock idles high (mode 3) gives the same results as one whose clock idles low (mode 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| csn | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| wp_n | input | 1 | Write protect, active low |
| busy | input | 1 | Commit engine is programming |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Drive enable for `miso` |
| mem_we | input | 1 | Array write strobe from the commit engine |
| mem_waddr | input | 9 | Array write address |
| mem_wdata | input | 8 | Array write data |
| wr_byte_valid | output | 1 | A write data byte is presented |
| wr_byte_addr | output | 9 | Address of the presented byte |
| wr_byte_data | output | 8 | The presented byte |
| wr_commit | output | 1 | Start programming of the presented bytes |
| sr_commit | output | 1 | Start programming of new protection bits |
| sr_bp | output | 2 | New protection bits {P1,P0} |

## Verification
The hardest situation to reach is a status read taken while a commit is still in progress. Only then can the frozen protection bits be seen next to a live write latch and busy flag. The bench acts as the commit engine. It holds `busy` high for several hundred cycles after each commit pulse, and it issues status reads and refused array reads inside that window. It also raises chip select one bit late or in the middle of a byte, to show that the latch, commit and protection-load outcomes depend on where the frame ends.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_SRDAT,
        ST_RDSR,
        ST_WAIT,
        ST_SKIP
    } fe_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    function automatic cmd_e decode_opc(input logic [BYTE_W-1:0] b);
        if (b[7:4] != 4'h0) return CMD_NONE;
        case (b[2:0])
            3'b110:  return CMD_WREN;
            3'b100:  return CMD_WRDI;
            3'b101:  return CMD_RDSR;
            3'b001:  return CMD_WRSR;
            3'b011:  return CMD_READ;
            3'b010:  return CMD_WRITE;
            default: return CMD_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic [1:0] bp,
                                                      input logic wel,
                                                      input logic wip);
        return {4'hF, bp, wel, wip};
    endfunction

endpackage

// File: rtl/spi_ee_edge.sv
module spi_ee_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic csn,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall
);
    logic sck_q;
    logic csn_q;

    // csn_q resets low so a select held low through reset is never a falling edge
    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            csn_q <= 1'b0;
        end else begin
            sck_q <= sck;
            csn_q <= csn;
        end
    end

    assign sck_rise = sck & ~sck_q;
    assign sck_fall = ~sck & sck_q;
    assign cs_fall  = ~csn & csn_q;
endmodule

// File: rtl/spi_ee_status.sv
module spi_ee_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       wp_n,
    input  logic       busy,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       bp_load,
    input  logic [1:0] bp_new,
    output logic       wel,
    output logic [1:0] bp
);
    logic       busy_q;
    logic       bp_pend_v;
    logic [1:0] bp_pend;
    logic       busy_fall;

    assign busy_fall = busy_q & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            wel       <= 1'b0;
            bp        <= 2'b00;
            bp_pend   <= 2'b00;
            bp_pend_v <= 1'b0;
        end else begin
            busy_q <= busy;
            if (!wp_n || wel_clr || busy_fall) wel <= 1'b0;
            else if (wel_set)                  wel <= 1'b1;
            if (bp_load) begin
                bp_pend   <= bp_new;
                bp_pend_v <= 1'b1;
            end else if (busy_fall && bp_pend_v) begin
                bp        <= bp_pend;
                bp_pend_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_frontend.sv
module spi_eeprom_frontend
    import spi_ee_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int PAGE  = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(PAGE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sck,
    input  logic          csn,
    input  logic          mosi,
    input  logic          wp_n,
    input  logic          busy,
    output logic          miso,
    output logic          miso_oe,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_waddr,
    input  logic [7:0]    mem_wdata,
    output logic          wr_byte_valid,
    output logic [AW-1:0] wr_byte_addr,
    output logic [7:0]    wr_byte_data,
    output logic          wr_commit,
    output logic          sr_commit,
    output logic [1:0]    sr_bp
);
    logic        sck_rise, sck_fall, cs_fall;
    fe_state_e   state;
    cmd_e        cmd_q;
    logic [2:0]  bitcnt;
    logic [6:0]  shreg;
    logic        addr_hi;
    logic [AW-1:0] addr_q;
    logic [7:0]  out_sr;
    logic        miso_q, oe_q, clean, wrote_any;
    logic        wel_set_q, wel_clr_q;
    logic [1:0]  sr_new_q;
    logic        wel;
    logic [1:0]  bp;

    logic [7:0]    in_byte;
    logic [8:0]    full_addr;
    logic [AW-1:0] raddr;
    logic [7:0]    rdata;
    logic [7:0]    status_byte;
    cmd_e          opc_cmd;

    assign in_byte     = {shreg, mosi};
    assign full_addr   = {addr_hi, in_byte};
    assign raddr       = (state == ST_ADDR) ? full_addr[AW-1:0] : addr_q;
    assign status_byte = pack_status(bp, wel, busy);
    assign opc_cmd     = decode_opc(in_byte);
    assign miso        = miso_q;
    assign miso_oe     = oe_q;

    spi_ee_edge edge_i (
        .clk(clk), .rst(rst), .sck(sck), .csn(csn),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall)
    );

    spi_ee_status status_i (
        .clk(clk), .rst(rst), .wp_n(wp_n), .busy(busy),
        .wel_set(wel_set_q), .wel_clr(wel_clr_q),
        .bp_load(sr_commit), .bp_new(sr_bp),
        .wel(wel), .bp(bp)
    );

    spi_ee_array #(.DEPTH(DEPTH), .AW(AW)) array_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(raddr), .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            cmd_q         <= CMD_NONE;
            bitcnt        <= '0;
            shreg         <= '0;
            addr_hi       <= 1'b0;
            addr_q        <= '0;
            out_sr        <= '0;
            miso_q        <= 1'b0;
            oe_q          <= 1'b0;
            clean         <= 1'b0;
            wrote_any     <= 1'b0;
            wel_set_q     <= 1'b0;
            wel_clr_q     <= 1'b0;
            sr_new_q      <= '0;
            wr_byte_valid <= 1'b0;
            wr_byte_addr  <= '0;
            wr_byte_data  <= '0;
            wr_commit     <= 1'b0;
            sr_commit     <= 1'b0;
            sr_bp         <= '0;
        end else begin
            wr_byte_valid <= 1'b0;
            wr_commit     <= 1'b0;
            sr_commit     <= 1'b0;
            wel_set_q     <= 1'b0;
            wel_clr_q     <= 1'b0;
            if (csn) begin
                // frame end: act on commands whose last bit fell on the boundary
                if (state == ST_WAIT && clean) begin
                    case (cmd_q)
                        CMD_WREN: wel_set_q <= 1'b1;
                        CMD_WRDI: wel_clr_q <= 1'b1;
                        CMD_WRSR: if (wel) begin
                            sr_commit <= 1'b1;
                            sr_bp     <= sr_new_q;
                        end
                        default: ;
                    endcase
                end
                if (state == ST_WDAT && bitcnt == 3'd0 && wrote_any && wel)
                    wr_commit <= 1'b1;
                state <= ST_IDLE;
                oe_q  <= 1'b0;
            end else if (cs_fall) begin
                state     <= ST_OPC;
                bitcnt    <= '0;
                clean     <= 1'b1;
                wrote_any <= 1'b0;
                oe_q      <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (sck_rise) begin
                    shreg  <= in_byte[6:0];
                    bitcnt <= bitcnt + 3'd1;
                    if (state == ST_WAIT) clean <= 1'b0;
                    if (bitcnt == 3'd7) begin
                        case (state)
                            ST_OPC: begin
                                cmd_q   <= opc_cmd;
                                addr_hi <= in_byte[3];
                                case (opc_cmd)
                                    CMD_WREN, CMD_WRDI: state <= ST_WAIT;
                                    CMD_RDSR: begin
                                        state  <= ST_RDSR;
                                        out_sr <= status_byte;
                                    end
                                    CMD_WRSR:  state <= (wel && !busy) ? ST_SRDAT : ST_SKIP;
                                    CMD_READ:  state <= busy ? ST_SKIP : ST_ADDR;
                                    CMD_WRITE: state <= (wel && !busy) ? ST_ADDR : ST_SKIP;
                                    default:   state <= ST_SKIP;
                                endcase
                            end
                            ST_ADDR: begin
                                if (cmd_q == CMD_READ) begin
                                    out_sr <= rdata;
                                    addr_q <= full_addr[AW-1:0] + AW'(1);
                                    state  <= ST_RDAT;
                                end else begin
                                    addr_q <= full_addr[AW-1:0];
                                    state  <= ST_WDAT;
                                end
                            end
                            ST_RDAT: begin
                                out_sr <= rdata;
                                addr_q <= addr_q + AW'(1);
                            end
                            ST_RDSR: out_sr <= status_byte;
                            ST_WDAT: begin
                                wr_byte_valid <= 1'b1;
                                wr_byte_addr  <= addr_q;
                                wr_byte_data  <= in_byte;
                                wrote_any     <= 1'b1;
                                addr_q <= {addr_q[AW-1:PW], PW'(addr_q[PW-1:0] + PW'(1))};
                            end
                            ST_SRDAT: begin
                                sr_new_q <= in_byte[3:2];
                                state    <= ST_WAIT;
                            end
                            default: ;
                        endcase
                    end
                end else if (sck_fall && (state == ST_RDAT || state == ST_RDSR)) begin
                    miso_q <= out_sr[7];
                    out_sr <= {out_sr[6:0], 1'b0};
                    oe_q   <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk (
    input logic clk,
    input logic rst,
    input logic csn,
    input logic sck,
    input logic wp_n,
    input logic busy,
    input logic wel,
    input logic miso_oe,
    input logic wr_commit,
    input logic sr_commit
);
    assert_oe_off_after_deselect_R11: assert property (@(posedge clk) disable iff (rst)
        csn |=> !miso_oe);

    assert_oe_starts_on_fall_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(miso_oe) |-> !$past(sck));

    assert_wp_clears_latch_R4: assert property (@(posedge clk) disable iff (rst)
        !wp_n |=> !wel);

    assert_busy_end_clears_latch_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> !wel);

    assert_write_commit_needs_latch_R9: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> ($past(wel) && $past(csn)));

    assert_sr_commit_needs_latch_R9: assert property (@(posedge clk) disable iff (rst)
        sr_commit |-> ($past(wel) && $past(csn)));
endmodule

bind spi_eeprom_frontend spi_ee_chk chk_i (
    .clk(clk), .rst(rst), .csn(csn), .sck(sck), .wp_n(wp_n), .busy(busy),
    .wel(wel), .miso_oe(miso_oe), .wr_commit(wr_commit), .sr_commit(sr_commit)
);

// File: tb/spi_eeprom_frontend_tb_top.sv
module spi_eeprom_frontend_tb_top;
    localparam int BUSYC = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, csn = 1'b0, mosi = 1'b0, wp_n = 1'b1, busy = 1'b0;
    logic miso, miso_oe;
    logic mem_we = 1'b0;
    logic [8:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;
    logic wr_byte_valid, wr_commit, sr_commit;
    logic [8:0] wr_byte_addr;
    logic [7:0] wr_byte_data;
    logic [1:0] sr_bp;

    int nchk = 0, nerr = 0;
    int n_wc = 0, n_sc = 0;
    logic [1:0] last_bp = '0;
    logic mode3 = 1'b0;
    logic preload_done = 1'b0;
    logic rxb [64];
    logic oeb [64];
    logic [16:0] staged [$];
    logic [16:0] eng_q [$];

    always #10 clk = ~clk;

    spi_eeprom_frontend dut_i (
        .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .wp_n(wp_n),
        .busy(busy), .miso(miso), .miso_oe(miso_oe),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .wr_byte_valid(wr_byte_valid), .wr_byte_addr(wr_byte_addr),
        .wr_byte_data(wr_byte_data), .wr_commit(wr_commit),
        .sr_commit(sr_commit), .sr_bp(sr_bp)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 5) % 256);
    endfunction

    function automatic logic [7:0] rxbyte(input int k);
        logic [7:0] r;
        for (int j = 0; j < 8; j++) r[7-j] = rxb[8*k+j];
        return r;
    endfunction

    function automatic logic any_oe(input int n);
        logic r = 1'b0;
        for (int j = 0; j < n; j++) r = r | oeb[j];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor of the handoff side
    always @(negedge clk) begin
        if (wr_byte_valid) staged.push_back({wr_byte_addr, wr_byte_data});
        if (wr_commit) n_wc++;
        if (sr_commit) begin
            n_sc++;
            last_bp = sr_bp;
        end
    end

    // commit engine stand-in: preloads the array, then programs after each commit
    initial begin
        @(negedge clk);
        while (rst) @(negedge clk);
        for (int i = 0; i < 512; i++) begin
            mem_we = 1'b1; mem_waddr = 9'(i); mem_wdata = pat(i);
            @(negedge clk);
        end
        mem_we = 1'b0;
        preload_done = 1'b1;
        forever begin
            @(negedge clk);
            if (wr_commit || sr_commit) begin
                eng_q = staged;
                busy = 1'b1;
                repeat (BUSYC) @(negedge clk);
                foreach (eng_q[k]) begin
                    mem_we = 1'b1; mem_waddr = eng_q[k][16:8]; mem_wdata = eng_q[k][7:0];
                    @(negedge clk);
                end
                mem_we = 1'b0;
                busy = 1'b0;
            end
        end
    end

    task automatic frame(input logic [63:0] txv, input int nbits, input logic nofall);
        staged.delete();
        for (int j = 0; j < 64; j++) begin rxb[j] = 1'b0; oeb[j] = 1'b0; end
        @(negedge clk);
        if (!nofall) csn = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sck = 1'b0; mosi = txv[63-i];
            repeat (2) @(negedge clk);
            rxb[i] = miso; oeb[i] = miso_oe;
            sck = 1'b1;
            repeat (2) @(negedge clk);
        end
        csn = 1'b1;
        repeat (2) @(negedge clk);
        sck = mode3;
        repeat (2) @(negedge clk);
    endtask

    task automatic rdsr_expect(input logic [7:0] exp, input string tag);
        frame({8'h05, 56'h0}, 24, 1'b0);
        chk({tag, " status byte 1"}, 32'(rxbyte(1)), 32'(exp));
        chk({tag, " status byte 2"}, 32'(rxbyte(2)), 32'(exp));
    endtask

    task automatic wren();
        frame({8'h06, 56'h0}, 8, 1'b0);
    endtask

    task automatic wrdi();
        frame({8'h04, 56'h0}, 8, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R11 reset oe", 32'(miso_oe), 0);
        chk("R6 reset commit", 32'(wr_commit), 0);
        chk("R7 reset sr commit", 32'(sr_commit), 0);
        rst = 1'b0;
        wait (preload_done);
        // R12: select low since reset, no falling edge: command must be ignored
        frame({8'h06, 56'h0}, 8, 1'b1);
        rdsr_expect(8'hF0, "R12 no frame without select fall");
        chk("R11 oe low before data phase", 32'(oeb[7]), 0);
        chk("R11 oe high at first data fall", 32'(oeb[8]), 1);

        // R1/R3: set latch with bit3 set, clear latch
        frame({8'h0E, 56'h0}, 8, 1'b0);
        rdsr_expect(8'hF2, "R1 R3 set latch opcode 0E");
        wrdi();
        rdsr_expect(8'hF0, "R3 clear latch");
        frame({8'h06, 56'h0}, 9, 1'b0);
        rdsr_expect(8'hF0, "R3 extra clock cancels set");

        // R4: write protect low clears the latch
        wren();
        rdsr_expect(8'hF2, "R4 latch set before protect");
        @(negedge clk); wp_n = 1'b0;
        repeat (3) @(negedge clk); wp_n = 1'b1;
        rdsr_expect(8'hF0, "R4 protect low clears latch");

        // R5/R1: read across the top with address bit 8 in the opcode
        frame({8'h0B, 8'hFE, 48'h0}, 48, 1'b0);
        chk("R5 oe before data", 32'(oeb[15]), 0);
        chk("R5 oe at first data fall", 32'(oeb[16]), 1);
        chk("R5 read 1FE", 32'(rxbyte(2)), 32'(pat(510)));
        chk("R5 read 1FF", 32'(rxbyte(3)), 32'(pat(511)));
        chk("R5 wrap to 000", 32'(rxbyte(4)), 32'(pat(0)));
        chk("R5 read 001", 32'(rxbyte(5)), 32'(pat(1)));
        frame({8'h03, 8'h05, 48'h0}, 32, 1'b0);
        chk("R1 read low half 005", 32'(rxbyte(2)), 32'(pat(5)));
        chk("R1 read low half 006", 32'(rxbyte(3)), 32'(pat(6)));

        // R9: write refused without latch
        frame({8'h02, 8'h10, 8'hAA, 40'h0}, 24, 1'b0);
        chk("R9 no byte without latch", 32'(staged.size()), 0);
        repeat (4) @(negedge clk);
        chk("R9 no commit without latch", 32'(n_wc), 0);

        // R6: page write wrapping inside the page
        wren();
        frame({8'h0A, 8'h1E, 8'h11, 8'h22, 8'h33, 24'h0}, 40, 1'b0);
        chk("R6 byte count", 32'(staged.size()), 3);
        chk("R6 byte 0", 32'(staged[0]), {15'h0, 9'h11E, 8'h11});
        chk("R6 byte 1", 32'(staged[1]), {15'h0, 9'h11F, 8'h22});
        chk("R6 page wrap byte 2", 32'(staged[2]), {15'h0, 9'h110, 8'h33});
        repeat (4) @(negedge clk);
        chk("R6 commit pulse", 32'(n_wc), 1);
        chk("R6 engine busy", 32'(busy), 1);
        rdsr_expect(8'hF3, "R2 R9 status during busy");
        frame({8'h0B, 8'h1E, 48'h0}, 32, 1'b0);
        chk("R9 read refused while busy", 32'(any_oe(32)), 0);
        wait (busy == 1'b0);
        repeat (4) @(negedge clk);
        rdsr_expect(8'hF0, "R4 busy end clears latch");
        frame({8'h0B, 8'h1E, 48'h0}, 32, 1'b0);
        chk("R6 readback 11E", 32'(rxbyte(2)), 32'h11);
        chk("R6 readback 11F", 32'(rxbyte(3)), 32'h22);
        frame({8'h0B, 8'h10, 48'h0}, 24, 1'b0);
        chk("R6 readback 110", 32'(rxbyte(2)), 32'h33);

        // R6: frame ends mid-byte, no commit
        wren();
        frame({8'h02, 8'h40, 8'h55, 40'h0}, 27, 1'b0);
        chk("R6 one byte presented", 32'(staged.size()), 1);
        repeat (4) @(negedge clk);
        chk("R6 no commit mid-byte", 32'(n_wc), 1);
        rdsr_expect(8'hF2, "R6 latch kept after aborted write");
        wrdi();

        // R7/R8: protection load and frozen view
        wren();
        frame({8'h01, 8'h0C, 48'h0}, 16, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 sr commit", 32'(n_sc), 1);
        chk("R7 new bits", 32'(last_bp), 3);
        rdsr_expect(8'hF3, "R8 old bits during busy");
        wait (busy == 1'b0);
        repeat (4) @(negedge clk);
        rdsr_expect(8'hFC, "R8 new bits after busy");
        wren();
        frame({8'h01, 8'h00, 48'h0}, 17, 1'b0);
        repeat (4) @(negedge clk);
        chk("R7 late deselect refused", 32'(n_sc), 1);
        rdsr_expect(8'hFE, "R7 bits unchanged after late deselect");
        wrdi();
        frame({8'h01, 8'h00, 48'h0}, 16, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 sr load refused without latch", 32'(n_sc), 1);

        // R10: undefined commands
        frame({8'h20, 8'h0B, 8'h00, 40'h0}, 40, 1'b0);
        chk("R10 no output after bad opcode 20", 32'(any_oe(40)), 0);
        frame({8'h07, 8'h00, 48'h0}, 24, 1'b0);
        chk("R10 no output after bad opcode 07", 32'(any_oe(24)), 0);
        rdsr_expect(8'hFC, "R10 next frame decoded");

        // R13: clock idling high
        @(negedge clk); mode3 = 1'b1; sck = 1'b1;
        repeat (2) @(negedge clk);
        rdsr_expect(8'hFC, "R13 status in mode 3");
        frame({8'h03, 8'h05, 48'h0}, 24, 1'b0);
        chk("R13 read in mode 3", 32'(rxbyte(2)), 32'(pat(5)));
        chk("R13 oe at first data fall", 32'(oeb[16]), 1);
        mode3 = 1'b0; sck = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 oe low when idle", 32'(miso_oe), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule